// File: doc/BRIEF.md
# Channel Status Transfer Buffer

This block carries digital audio channel status between three stores of 24 words of 16 bits each. In every word the upper byte belongs to channel A and the lower byte to channel B. The receive store is loaded a word at a time by the receiver. A receive-side tick copies the whole receive store into the middle store in one block. A transmit-side tick copies the whole middle store into the transmit store in one block. The transmitter reads the transmit store by word index.

A host byte port reads and writes the middle store. There are two addressing modes. In one-byte mode an address names a word, a write fills both channel bytes, and a read returns channel A. In two-byte mode, address 2*word+0 is the A byte and 2*word+1 is the B byte.

Each automatic transfer has its own inhibit pin. A tick that arrives while its inhibit is set is dropped, not deferred. A sticky interrupt rises after every completed middle-to-transmit copy and is cleared by a write-one-to-clear pulse. A reserve mode keeps the first five words of the middle store for host writes only. To edit the middle store coherently, the host does the following in order:
1. Set the receive-side inhibit.
2. Wait for the interrupt.
3. Optionally set the transmit-side inhibit.
4. Write.
5. Release the inhibits in reverse order.

The receive word port uses valid/ready. `rx_ready` is held high, so the port never applies back-pressure and a word is taken in every cycle that `rx_valid` is high. All other pins are plain level or pulse controls.

Top module: `cst_xfer_buffer`

## Requirements
- R1: During and after reset, all three stores read zero and `irq_e2f` is low.
- R2: When `rx_valid` is high, `rx_word` is written into receive word `rx_idx` at the clock edge. An `rx_idx` of 24 or above is ignored. `rx_ready` is always high.
- R3: A `d2e_tick` with `d2e_inhibit` low copies all 24 receive words into the middle store at that edge. The result is visible in the next cycle.
- R4: With `cfg_reserve` high, a receive-to-middle copy leaves middle words 0 to 4, both bytes, unchanged. Words 5 to 23 are still copied.
- R5: A `d2e_tick` while `d2e_inhibit` is high changes nothing. Later clearing the inhibit does not replay it.
- R6: An `e2f_tick` with `e2f_inhibit` low copies all middle words, as they stood before that edge, into the transmit store. `tx_word` shows transmit word `tx_idx` combinationally, or zero for an index of 24 or above.
- R7: An `e2f_tick` while `e2f_inhibit` is high leaves the transmit store unchanged and does not raise the interrupt.
- R8: `irq_e2f` goes high after each completed middle-to-transmit copy and stays high until an `irq_clr` pulse. When a copy and a clear fall in the same cycle, the flag ends up high.
- R9: When `cfg_two_byte` is 0 (one-byte mode), a host write to address a < 24 sets both bytes of word a. `host_rdata` returns the A byte of word `host_addr`. Addresses of 24 or above are ignored on write and read as zero.
- R10: When `cfg_two_byte` is 1 (two-byte mode), address 2w addresses the A byte (bits 15:8) of word w, and address 2w+1 addresses the B byte (bits 7:0). Addresses of 48 or above are ignored on write and read as zero.
- R11: A host write in the same cycle as a receive-to-middle copy wins for the byte it addresses. The other byte of that word follows the copy rules of R3 and R4.
- R12: A host write in the same cycle as a middle-to-transmit copy does not reach the transmit store on that copy. The middle store does take the host value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Receive word valid |
| rx_ready | output | 1 | Receive word ready, always high |
| rx_idx | input | 5 | Receive word index |
| rx_word | input | 16 | Receive word, A byte in the upper half |
| d2e_tick | input | 1 | Request for a receive-to-middle block copy |
| e2f_tick | input | 1 | Request for a middle-to-transmit block copy |
| cfg_reserve | input | 1 | Keep middle words 0 to 4 for host writes only |
| cfg_two_byte | input | 1 | Host addressing mode: 0 is one-byte, 1 is two-byte |
| d2e_inhibit | input | 1 | Drop receive-to-middle ticks |
| e2f_inhibit | input | 1 | Drop middle-to-transmit ticks |
| host_wr_en | input | 1 | Host byte write strobe |
| host_addr | input | 6 | Host byte address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte from the middle store |
| tx_idx | input | 5 | Transmit word index |
| tx_word | output | 16 | Transmit store word |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt |
| irq_e2f | output | 1 | Sticky interrupt for a completed middle-to-transmit copy |

## Verification
Two things can hit the middle store in the same cycle: a host byte write and an automatic block copy. A receive-side copy contends for the same word. A transmit-side copy reads the old contents while the host changes them. Directed cases place a host write on the exact edge of a receive-to-middle copy, with reserve both off and on, and on the exact edge of a middle-to-transmit copy. The random phase makes these collisions happen often by firing host writes and both ticks at high rates. The results are judged by scanning every byte of the middle store and every transmit word against a bench model. In that model the host byte overrides the copied byte, and the transmit store takes the values from before the edge.

// File: rtl/cst_pkg.sv
package cst_pkg;
  typedef enum logic {
    HOST_ONE_BYTE = 1'b0,
    HOST_TWO_BYTE = 1'b1
  } host_mode_e;
endpackage

// File: rtl/cst_dstore.sv
module cst_dstore #(
  parameter int WORDS = 24,
  parameter int WW    = 16,
  parameter int IW    = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rx_valid_i,
  input  logic [IW-1:0]             rx_idx_i,
  input  logic [WW-1:0]             rx_word_i,
  output logic [WORDS-1:0][WW-1:0]  d_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q <= '0;
    end else begin
      for (int w = 0; w < WORDS; w++) begin
        if (rx_valid_i && rx_idx_i == IW'(w)) d_q[w] <= rx_word_i;
      end
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_rx_chk
    assert_rx_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid_i && rx_idx_i == IW'(g)) |=> d_q[g] == $past(rx_word_i));
  end
endmodule

// File: rtl/cst_host_port.sv
module cst_host_port
  import cst_pkg::*;
#(
  parameter int WORDS = 24,
  parameter int BW    = 8,
  parameter int AW    = 6,
  localparam int WW   = 2 * BW
) (
  input  logic                      wr_en_i,
  input  logic                      two_byte_i,
  input  logic [AW-1:0]             addr_i,
  input  logic [WORDS-1:0][WW-1:0]  e_i,
  output logic [WORDS-1:0]          hit_a_o,
  output logic [WORDS-1:0]          hit_b_o,
  output logic [BW-1:0]             rdata_o
);
  host_mode_e mode;
  assign mode = host_mode_e'(two_byte_i);

  always_comb begin
    hit_a_o = '0;
    hit_b_o = '0;
    rdata_o = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (mode == HOST_TWO_BYTE) begin
        if (addr_i == AW'(2 * w)) begin
          hit_a_o[w] = wr_en_i;
          rdata_o    = e_i[w][WW-1:BW];
        end
        if (addr_i == AW'(2 * w + 1)) begin
          hit_b_o[w] = wr_en_i;
          rdata_o    = e_i[w][BW-1:0];
        end
      end else if (addr_i == AW'(w)) begin
        hit_a_o[w] = wr_en_i;
        hit_b_o[w] = wr_en_i;
        rdata_o    = e_i[w][WW-1:BW];
      end
    end
  end
endmodule

// File: rtl/cst_estore.sv
module cst_estore #(
  parameter int WORDS     = 24,
  parameter int BW        = 8,
  parameter int RES_WORDS = 5,
  localparam int WW       = 2 * BW
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      d2e_tick_i,
  input  logic                      d2e_inhibit_i,
  input  logic                      reserve_i,
  input  logic [WORDS-1:0][WW-1:0]  d_i,
  input  logic [WORDS-1:0]          hit_a_i,
  input  logic [WORDS-1:0]          hit_b_i,
  input  logic [BW-1:0]             wbyte_i,
  output logic [WORDS-1:0][WW-1:0]  e_q
);
  logic                      d2e_go;
  logic [WORDS-1:0][WW-1:0]  e_nxt;

  assign d2e_go = d2e_tick_i && !d2e_inhibit_i;

  // Copy first, then the host byte lands on top of it.
  always_comb begin
    e_nxt = e_q;
    for (int w = 0; w < WORDS; w++) begin
      if (d2e_go && !(reserve_i && (w < RES_WORDS))) e_nxt[w] = d_i[w];
      if (hit_a_i[w]) e_nxt[w][WW-1:BW] = wbyte_i;
      if (hit_b_i[w]) e_nxt[w][BW-1:0]  = wbyte_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) e_q <= '0;
    else        e_q <= e_nxt;
  end

  assert_d2e_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (d2e_tick_i && !d2e_inhibit_i && !reserve_i && !(|hit_a_i) && !(|hit_b_i))
      |=> e_q == $past(d_i));

  assert_d2e_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (d2e_tick_i && d2e_inhibit_i && !(|hit_a_i) && !(|hit_b_i)) |=> $stable(e_q));

  for (genvar g = 0; g < WORDS; g++) begin : g_res_chk
    if (g < RES_WORDS) begin : g_res
      assert_reserve_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reserve_i && d2e_tick_i && !hit_a_i[g] && !hit_b_i[g]) |=> $stable(e_q[g]));
    end
    assert_host_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      hit_b_i[g] |=> e_q[g][BW-1:0] == $past(wbyte_i));
  end
endmodule

// File: rtl/cst_fstore.sv
module cst_fstore #(
  parameter int WORDS = 24,
  parameter int WW    = 16,
  parameter int IW    = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      e2f_tick_i,
  input  logic                      e2f_inhibit_i,
  input  logic                      irq_clr_i,
  input  logic [WORDS-1:0][WW-1:0]  e_i,
  input  logic [IW-1:0]             tx_idx_i,
  output logic [WW-1:0]             tx_word_o,
  output logic                      irq_q
);
  logic                      e2f_go;
  logic [WORDS-1:0][WW-1:0]  f_q;

  assign e2f_go = e2f_tick_i && !e2f_inhibit_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_q   <= '0;
      irq_q <= 1'b0;
    end else begin
      if (e2f_go) f_q <= e_i;
      if (e2f_go)         irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;
    end
  end

  always_comb begin
    tx_word_o = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (tx_idx_i == IW'(w)) tx_word_o = f_q[w];
    end
  end

  assert_e2f_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (e2f_tick_i && !e2f_inhibit_i) |=> f_q == $past(e_i));

  assert_e2f_skip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (e2f_tick_i && e2f_inhibit_i) |=> $stable(f_q));

  assert_irq_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (e2f_tick_i && !e2f_inhibit_i) |=> irq_q);

  assert_irq_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr_i && !(e2f_tick_i && !e2f_inhibit_i)) |=> !irq_q);
endmodule

// File: rtl/cst_xfer_buffer.sv
module cst_xfer_buffer #(
  parameter int WORDS     = 24,
  parameter int BW        = 8,
  parameter int RES_WORDS = 5,
  localparam int WW       = 2 * BW,
  localparam int IW       = $clog2(WORDS),
  localparam int AW       = $clog2(2 * WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [IW-1:0] rx_idx,
  input  logic [WW-1:0] rx_word,
  input  logic          d2e_tick,
  input  logic          e2f_tick,
  input  logic          cfg_reserve,
  input  logic          cfg_two_byte,
  input  logic          d2e_inhibit,
  input  logic          e2f_inhibit,
  input  logic          host_wr_en,
  input  logic [AW-1:0] host_addr,
  input  logic [BW-1:0] host_wdata,
  output logic [BW-1:0] host_rdata,
  input  logic [IW-1:0] tx_idx,
  output logic [WW-1:0] tx_word,
  input  logic          irq_clr,
  output logic          irq_e2f
);
  logic [WORDS-1:0][WW-1:0] d_q;
  logic [WORDS-1:0][WW-1:0] e_q;
  logic [WORDS-1:0]         hit_a;
  logic [WORDS-1:0]         hit_b;

  assign rx_ready = 1'b1;

  cst_dstore #(.WORDS(WORDS), .WW(WW), .IW(IW)) u_dstore (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid_i (rx_valid),
    .rx_idx_i   (rx_idx),
    .rx_word_i  (rx_word),
    .d_q        (d_q)
  );

  cst_host_port #(.WORDS(WORDS), .BW(BW), .AW(AW)) u_host (
    .wr_en_i    (host_wr_en),
    .two_byte_i (cfg_two_byte),
    .addr_i     (host_addr),
    .e_i        (e_q),
    .hit_a_o    (hit_a),
    .hit_b_o    (hit_b),
    .rdata_o    (host_rdata)
  );

  cst_estore #(.WORDS(WORDS), .BW(BW), .RES_WORDS(RES_WORDS)) u_estore (
    .clk           (clk),
    .rst_n         (rst_n),
    .d2e_tick_i    (d2e_tick),
    .d2e_inhibit_i (d2e_inhibit),
    .reserve_i     (cfg_reserve),
    .d_i           (d_q),
    .hit_a_i       (hit_a),
    .hit_b_i       (hit_b),
    .wbyte_i       (host_wdata),
    .e_q           (e_q)
  );

  cst_fstore #(.WORDS(WORDS), .WW(WW), .IW(IW)) u_fstore (
    .clk           (clk),
    .rst_n         (rst_n),
    .e2f_tick_i    (e2f_tick),
    .e2f_inhibit_i (e2f_inhibit),
    .irq_clr_i     (irq_clr),
    .e_i           (e_q),
    .tx_idx_i      (tx_idx),
    .tx_word_o     (tx_word),
    .irq_q         (irq_e2f)
  );
endmodule

// File: tb/test_cst_xfer_buffer.sv
`timescale 1ns/1ps
module test_cst_xfer_buffer;
  localparam int WORDS = 24, BW = 8, WW = 16, IW = 5, AW = 6, RES = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid, rx_ready, d2e_tick, e2f_tick, cfg_reserve, cfg_two_byte;
  logic d2e_inhibit, e2f_inhibit, host_wr_en, irq_clr, irq_e2f;
  logic [IW-1:0] rx_idx, tx_idx;
  logic [WW-1:0] rx_word, tx_word;
  logic [AW-1:0] host_addr;
  logic [BW-1:0] host_wdata, host_rdata;

  logic [WW-1:0] mD [WORDS];
  logic [WW-1:0] mE [WORDS];
  logic [WW-1:0] mF [WORDS];
  logic          mIrq;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cst_xfer_buffer i_cst_xfer_buffer (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_idx(rx_idx), .rx_word(rx_word), .d2e_tick(d2e_tick), .e2f_tick(e2f_tick),
    .cfg_reserve(cfg_reserve), .cfg_two_byte(cfg_two_byte),
    .d2e_inhibit(d2e_inhibit), .e2f_inhibit(e2f_inhibit),
    .host_wr_en(host_wr_en), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .tx_idx(tx_idx), .tx_word(tx_word),
    .irq_clr(irq_clr), .irq_e2f(irq_e2f)
  );

  function automatic logic [BW-1:0] exp_rd();
    int a = int'(host_addr);
    if (cfg_two_byte) begin
      if (a < 2 * WORDS) return (a % 2) ? mE[a/2][BW-1:0] : mE[a/2][WW-1:BW];
    end else if (a < WORDS) begin
      return mE[a][WW-1:BW];
    end
    return '0;
  endfunction

  function automatic logic [WW-1:0] exp_tx();
    if (int'(tx_idx) < WORDS) return mF[int'(tx_idx)];
    return '0;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    rx_valid = 0; d2e_tick = 0; e2f_tick = 0; host_wr_en = 0; irq_clr = 0;
  endtask

  // Model one clock edge from the inputs now applied, then move to the next falling edge.
  task automatic step();
    logic [WW-1:0] nD [WORDS];
    logic [WW-1:0] nE [WORDS];
    logic [WW-1:0] nF [WORDS];
    logic nIrq;
    int a;
    for (int w = 0; w < WORDS; w++) begin nD[w] = mD[w]; nE[w] = mE[w]; nF[w] = mF[w]; end
    nIrq = mIrq;
    if (rx_valid && int'(rx_idx) < WORDS) nD[int'(rx_idx)] = rx_word;
    if (d2e_tick && !d2e_inhibit)
      for (int w = 0; w < WORDS; w++) if (!(cfg_reserve && w < RES)) nE[w] = mD[w];
    if (host_wr_en) begin
      a = int'(host_addr);
      if (cfg_two_byte) begin
        if (a < 2 * WORDS) begin
          if (a % 2) nE[a/2][BW-1:0] = host_wdata;
          else       nE[a/2][WW-1:BW] = host_wdata;
        end
      end else if (a < WORDS) begin
        nE[a] = {host_wdata, host_wdata};
      end
    end
    if (e2f_tick && !e2f_inhibit) begin
      for (int w = 0; w < WORDS; w++) nF[w] = mE[w];
      nIrq = 1'b1;
    end else if (irq_clr) begin
      nIrq = 1'b0;
    end
    @(posedge clk);
    for (int w = 0; w < WORDS; w++) begin mD[w] = nD[w]; mE[w] = nE[w]; mF[w] = nF[w]; end
    mIrq = nIrq;
    @(negedge clk);
  endtask

  task automatic check_now(string req);
    check(req, "host_rdata", 32'(host_rdata), 32'(exp_rd()));
    check(req, "tx_word", 32'(tx_word), 32'(exp_tx()));
    check(req, "irq_e2f", 32'(irq_e2f), 32'(mIrq));
  endtask

  // Idle cycles that read back every middle byte and every transmit word.
  task automatic scan(string req);
    logic keep = cfg_two_byte;
    idle();
    cfg_two_byte = 1'b1;
    for (int a = 0; a < 2 * WORDS; a++) begin
      host_addr = AW'(a);
      tx_idx = IW'(a % WORDS);
      #1;
      check_now(req);
      step();
    end
    cfg_two_byte = keep;
  endtask

  task automatic hwrite(logic [AW-1:0] a, logic [BW-1:0] d);
    host_wr_en = 1; host_addr = a; host_wdata = d;
  endtask

  initial begin : watchdog
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    idle();
    rx_idx = 0; rx_word = 0; tx_idx = 0; host_addr = 0; host_wdata = 0;
    cfg_reserve = 0; cfg_two_byte = 0; d2e_inhibit = 0; e2f_inhibit = 0;
    for (int w = 0; w < WORDS; w++) begin mD[w] = 0; mE[w] = 0; mF[w] = 0; end
    mIrq = 0;
    repeat (3) @(negedge clk);
    check("R1", "irq in reset", 32'(irq_e2f), 0);
    check("R2", "rx_ready", 32'(rx_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    scan("R1");

    // R2 and R3: load the receive store, including an index that is ignored, then copy.
    for (int w = 0; w < WORDS; w++) begin
      idle(); rx_valid = 1; rx_idx = IW'(w); rx_word = WW'(16'hA100 + w * 16'h0101); step();
    end
    idle(); rx_valid = 1; rx_idx = 5'd30; rx_word = 16'hDEAD; step();
    idle(); d2e_tick = 1; step();
    scan("R2/R3");
    check("R3", "word 7 after copy", 32'(mE[7]), 32'(16'hA100 + 7 * 16'h0101));

    // R6 and R8: copy toward the transmit store, then clear, then set and clear together.
    idle(); e2f_tick = 1; step();
    tx_idx = 5'd3; #1;
    check("R6", "tx word 3", 32'(tx_word), 32'(16'hA100 + 3 * 16'h0101));
    check("R8", "irq after copy", 32'(irq_e2f), 1);
    idle(); irq_clr = 1; step();
    check("R8", "irq after clear", 32'(irq_e2f), 0);
    idle(); step();
    check("R8", "irq stays low", 32'(irq_e2f), 0);
    idle(); e2f_tick = 1; irq_clr = 1; step();
    check("R8", "set beats clear", 32'(irq_e2f), 1);
    tx_idx = 5'd27; #1;
    check("R6", "tx out of range", 32'(tx_word), 0);

    // R4: reserve mode, host edits word 2 A and word 4 B, new receive data then copy.
    cfg_reserve = 1; cfg_two_byte = 1;
    idle(); hwrite(6'd4, 8'h5C); step();
    idle(); hwrite(6'd9, 8'h3E); step();
    for (int w = 0; w < WORDS; w++) begin
      idle(); rx_valid = 1; rx_idx = IW'(w); rx_word = WW'(16'h1000 + w); step();
    end
    idle(); d2e_tick = 1; step();
    check("R4", "reserved word 2", 32'(mE[2]), 32'({8'h5C, 8'h00 + 8'(16'hA100 + 2 * 16'h0101)}));
    scan("R4");
    idle(); cfg_two_byte = 1; host_addr = 6'd0; #1;
    check("R4", "reserved word 0 A", 32'(host_rdata), 32'(8'hA1));
    host_addr = 6'd12; #1;
    check("R4", "word 6 copied A", 32'(host_rdata), 32'(8'h10));
    cfg_reserve = 0;

    // R5: dropped tick is not replayed once the inhibit falls.
    for (int w = 0; w < WORDS; w++) begin
      idle(); rx_valid = 1; rx_idx = IW'(w); rx_word = WW'(16'h7700 + w); step();
    end
    d2e_inhibit = 1; idle(); d2e_tick = 1; step();
    d2e_inhibit = 0; idle(); step(); step();
    host_addr = 6'd20; #1;
    check("R5", "word 10 A untouched", 32'(host_rdata), 32'(8'h10));
    scan("R5");

    // R7: inhibited transmit-side tick.
    idle(); irq_clr = 1; step();
    e2f_inhibit = 1; idle(); e2f_tick = 1; step();
    e2f_inhibit = 0;
    check("R7", "irq stays low", 32'(irq_e2f), 0);
    scan("R7");

    // R9: one-byte mode write, read, and ignored addresses.
    cfg_two_byte = 0;
    idle(); hwrite(6'd7, 8'h9B); step();
    idle(); host_addr = 6'd7; #1;
    check("R9", "one-byte read A", 32'(host_rdata), 32'(8'h9B));
    host_addr = 6'd30; #1;
    check("R9", "one-byte out of range read", 32'(host_rdata), 0);
    idle(); hwrite(6'd40, 8'hEE); step();
    scan("R9");
    check("R9", "word 7 both bytes", 32'(mE[7]), 32'(16'h9B9B));

    // R10: two-byte write beyond range.
    cfg_two_byte = 1;
    idle(); hwrite(6'd50, 8'h44); step();
    idle(); host_addr = 6'd50; #1;
    check("R10", "two-byte out of range read", 32'(host_rdata), 0);
    idle(); hwrite(6'd15, 8'h61); step();
    idle(); host_addr = 6'd15; #1;
    check("R10", "word 7 B byte", 32'(host_rdata), 32'(8'h61));
    scan("R10");

    // R11: host write on the edge of a receive-side copy.
    idle(); hwrite(6'd21, 8'hC3); d2e_tick = 1; step();
    check("R11", "word 10 host B and copied A", 32'(mE[10]), 32'({8'h77, 8'hC3}));
    idle(); host_addr = 6'd20; #1;
    check("R11", "word 10 A from copy", 32'(host_rdata), 32'(8'h77));
    host_addr = 6'd21; #1;
    check("R11", "word 10 B from host", 32'(host_rdata), 32'(8'hC3));

    // R12: host write on the edge of a transmit-side copy.
    idle(); hwrite(6'd12, 8'h2D); e2f_tick = 1; step();
    idle(); tx_idx = 5'd6; host_addr = 6'd12; #1;
    check("R12", "tx word 6 is pre-write", 32'(tx_word), 32'(16'h7706));
    check("R12", "middle word 6 A is host", 32'(host_rdata), 32'(8'h2D));
    scan("R12");

    // Random phase with frequent collisions.
    for (int c = 0; c < 4000; c++) begin
      idle();
      rx_valid    = ($urandom % 2) == 0;
      rx_idx      = IW'($urandom % 32);
      rx_word     = WW'($urandom);
      d2e_tick    = ($urandom % 5) == 0;
      e2f_tick    = ($urandom % 5) == 0;
      d2e_inhibit = ($urandom % 4) == 0;
      e2f_inhibit = ($urandom % 4) == 0;
      host_wr_en  = ($urandom % 3) == 0;
      host_addr   = AW'($urandom % 64);
      host_wdata  = BW'($urandom);
      irq_clr     = ($urandom % 8) == 0;
      tx_idx      = IW'($urandom % 32);
      if ($urandom % 50 == 0) cfg_reserve = ~cfg_reserve;
      cfg_two_byte = ($urandom % 2) == 0;
      step();
      check_now("R3/R4/R6/R8/R9/R10/R11/R12");
    end
    d2e_inhibit = 0; e2f_inhibit = 0;
    scan("R11/R12");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule